// File: doc/BRIEF.md
# Configuration Stream Payload Locator

This block watches the byte stream of a configuration image as it arrives and finds where the raw configuration data starts. It first steps over a fixed prefix and a chain of four length-prefixed text fields. It then searches the bytes that follow for a start marker. The marker and the rule that turns a match into a start offset both depend on the device mode. A run is started with a pulse that carries the image's total length and the mode. Image bytes then arrive one per cycle whenever `in_valid` is high.

Once the marker is found, the block raises a one-cycle report with the payload's start offset and length. It then forwards every payload byte, in order, on its output stream. A three-byte hold-back window delays every byte by the same amount. This lets the marker bytes that belong to the payload in raw mode still be forwarded after the match is seen. If the stream ends without a match, the block flags an error and forwards nothing.

Top module: `cfl_locator`

## Requirements
- R1: A run starts only on a `start` pulse while `busy` is low. `mode` and `total_len` are captured at that edge, and later changes to them have no effect on the run. A `start` pulse while `busy` is high is ignored. `busy` stays high from the cycle after an accepted start until the run ends.
- R2: Byte indices count from 0 and advance only on cycles with `in_valid` high. The first field length is the byte at index 15. Each field length is read at the current pointer, and the pointer then moves forward by that length plus 3, four times in all. Only bytes at or after the final pointer take part in marker matching. If the fourth length byte is never reached, or the final pointer lies past the stream, the run ends in error.
- R3: With `mode`=0 (packed), the marker is the first byte 8'hFF followed directly by a byte whose bits [7:4] equal 4'h3, with both bytes in the search region. The start offset is the index of that 8'hFF plus 2.
- R4: With `mode`=1 (raw), the marker is the first run of four consecutive 8'hFF bytes in the search region. The start offset is the index of the first of those four bytes.
- R5: A successful run gives exactly one `rep_valid` pulse. In that cycle, `start_off` holds the start offset and `pay_len` holds `total_len` minus the start offset. This may be zero when the marker ends the stream.
- R6: The block forwards exactly the bytes from the start offset up to `total_len`-1, in order, one per `out_valid` cycle. In raw mode this includes the four marker bytes. No byte is forwarded before the report.
- R7: If no marker is found by the last byte, or `total_len` is 0, then `err` rises together with `done`. In that case there is no report and no byte is forwarded. `err` holds until the next accepted start.
- R8: `done` is a one-cycle pulse that ends every run, with `busy` low in the same cycle. In a successful run it comes with or after the last forwarded byte.
- R9: `in_valid` and `in_byte` are ignored while idle and after the last byte of the run has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a run (accepted while idle) |
| mode | input | 1 | 0 = packed marker rule, 1 = raw marker rule |
| total_len | input | LEN_W | Number of bytes in the image |
| in_valid | input | 1 | `in_byte` carries the next image byte |
| in_byte | input | 8 | Image byte |
| busy | output | 1 | Run in progress |
| out_valid | output | 1 | `out_byte` carries a payload byte |
| out_byte | output | 8 | Payload byte |
| rep_valid | output | 1 | Report pulse: marker found |
| start_off | output | LEN_W | Payload start offset in the image |
| pay_len | output | LEN_W | Payload length in bytes |
| done | output | 1 | Run finished (pulse) |
| err | output | 1 | Run ended without a marker |

## Verification
The bench places lookalike markers inside the header fields: an 8'hFF followed by a 4'h3-nibble byte, and runs of 8'hFF. A design that starts its search too early would lock onto them and report a start inside the header. It also sends partial markers: 8'hFF followed by a 4'h4-nibble byte, 8'hFF 8'hFF 8'h3x, a broken run of three 8'hFF, and a run of six. These catch an off-by-one in the pair or run tracking, which would move the start offset or miss the marker. It also covers a marker that ends the stream (empty payload), a missing marker, a header that runs past the stream, and a zero length; each must end in a clean report or a clean error. Input gaps, mode toggling and extra start pulses mid-run expose a design that counts idle cycles or fails to hold its captured settings.

// File: rtl/cfl_pkg.sv
package cfl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FEED  = 2'd1,
    PH_DRAIN = 2'd2
  } phase_t;

  typedef enum logic {
    MODE_PACKED = 1'b0,
    MODE_RAW    = 1'b1
  } mode_t;

  localparam logic [7:0] MARK_BYTE = 8'hFF;
  localparam logic [3:0] PACKED_NIB = 4'h3;

endpackage

// File: rtl/cfl_rst_sync.sv
module cfl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/cfl_hdr_walk.sv
module cfl_hdr_walk #(
  parameter int IDX_W     = 18,
  parameter int HDR_OFS   = 15,
  parameter int N_FIELDS  = 4,
  parameter int FIELD_ADJ = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             take,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       din,
  output logic             in_region
);

  localparam int CNT_W = $clog2(N_FIELDS + 1);

  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             walking;

  assign walking   = (cnt_q < CNT_W'(N_FIELDS));
  assign in_region = !walking && (idx >= ptr_q);

  always_comb begin
    ptr_d = ptr_q;
    cnt_d = cnt_q;
    if (init) begin
      ptr_d = IDX_W'(HDR_OFS);
      cnt_d = '0;
    end else if (take && walking && (idx == ptr_q)) begin
      ptr_d = ptr_q + IDX_W'(din) + IDX_W'(FIELD_ADJ);
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/cfl_pre_det.sv
module cfl_pre_det
  import cfl_pkg::*;
#(
  parameter int IDX_W   = 18,
  parameter int RUN_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             raw_mode,
  input  logic             look,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       din,
  output logic             hit,
  output logic [IDX_W-1:0] hit_start
);

  localparam int RUN_W = $clog2(RUN_LEN);
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(RUN_LEN - 1);

  logic [RUN_W-1:0] run_q, run_d;
  logic             prev_ff_q, prev_ff_d;
  logic             is_mark;

  assign is_mark = (din == MARK_BYTE);

  always_comb begin
    if (raw_mode) begin
      hit       = look && is_mark && (run_q == RUN_TOP);
      hit_start = idx - IDX_W'(RUN_LEN - 1);
    end else begin
      hit       = look && prev_ff_q && (din[7:4] == PACKED_NIB);
      hit_start = idx + IDX_W'(1);
    end
  end

  always_comb begin
    run_d     = run_q;
    prev_ff_d = prev_ff_q;
    if (init) begin
      run_d     = '0;
      prev_ff_d = 1'b0;
    end else if (look) begin
      prev_ff_d = is_mark;
      if (!is_mark)             run_d = '0;
      else if (run_q != RUN_TOP) run_d = run_q + RUN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= '0;
      prev_ff_q <= 1'b0;
    end else begin
      run_q     <= run_d;
      prev_ff_q <= prev_ff_d;
    end
  end

endmodule

// File: rtl/cfl_hold_win.sv
module cfl_hold_win #(
  parameter int DEPTH = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shift,
  input  logic [7:0] din,
  output logic [7:0] dout
);

  logic [7:0] stage_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic [7:0] feed;
    if (s == 0) begin : g_head
      assign feed = din;
    end else begin : g_body
      assign feed = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     stage_q[s] <= '0;
      else if (shift) stage_q[s] <= feed;
    end
  end

  assign dout = stage_q[DEPTH-1];

endmodule

// File: rtl/cfl_locator.sv
module cfl_locator
  import cfl_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int HDR_OFS   = 15,
  parameter int N_FIELDS  = 4,
  parameter int FIELD_ADJ = 3,
  parameter int RUN_LEN   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode,
  input  logic [LEN_W-1:0] total_len,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             busy,
  output logic             out_valid,
  output logic [7:0]       out_byte,
  output logic             rep_valid,
  output logic [LEN_W-1:0] start_off,
  output logic [LEN_W-1:0] pay_len,
  output logic             done,
  output logic             err
);

  localparam int IDX_W = LEN_W + 2;
  localparam int WIN   = RUN_LEN - 1;

  logic rst_sync_n;

  phase_t           ph_q, ph_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [LEN_W-1:0] len_q, len_d;
  mode_t            mode_q, mode_d;
  logic             found_q, found_d;
  logic [IDX_W-1:0] st_q, st_d;
  logic             err_q, err_d;
  logic             done_q, done_d;
  logic             rep_q, rep_d;
  logic [LEN_W-1:0] rep_off_q, rep_off_d;
  logic [LEN_W-1:0] rep_len_q, rep_len_d;
  logic             ov_q, ov_d;
  logic [7:0]       ob_q, ob_d;

  logic             init, take, step, look, in_region, hit;
  logic [IDX_W-1:0] hit_start, st_nx, exit_idx;
  logic             found_nx, fwd, last_in, last_drain;
  logic [7:0]       win_out, win_in;

  cfl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign init = (ph_q == PH_IDLE) && start;
  assign take = (ph_q == PH_FEED) && in_valid;
  assign step = take || (ph_q == PH_DRAIN);
  assign look = take && in_region && !found_q;

  cfl_hdr_walk #(
    .IDX_W     (IDX_W),
    .HDR_OFS   (HDR_OFS),
    .N_FIELDS  (N_FIELDS),
    .FIELD_ADJ (FIELD_ADJ)
  ) u_walk (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .init      (init),
    .take      (take),
    .idx       (idx_q),
    .din       (in_byte),
    .in_region (in_region)
  );

  cfl_pre_det #(
    .IDX_W   (IDX_W),
    .RUN_LEN (RUN_LEN)
  ) u_det (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .init      (init),
    .raw_mode  (mode_q == MODE_RAW),
    .look      (look),
    .idx       (idx_q),
    .din       (in_byte),
    .hit       (hit),
    .hit_start (hit_start)
  );

  assign win_in = take ? in_byte : 8'h00;

  cfl_hold_win #(
    .DEPTH (WIN)
  ) u_win (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .shift (step),
    .din   (win_in),
    .dout  (win_out)
  );

  // byte leaving the window this cycle has index idx_q - WIN
  assign found_nx   = found_q || hit;
  assign st_nx      = hit ? hit_start : st_q;
  assign exit_idx   = idx_q - IDX_W'(WIN);
  assign fwd        = step && (idx_q >= IDX_W'(WIN)) && found_nx && (exit_idx >= st_nx);
  assign last_in    = take && (idx_q == IDX_W'(len_q) - IDX_W'(1));
  assign last_drain = (ph_q == PH_DRAIN) && (idx_q == IDX_W'(len_q) + IDX_W'(WIN - 1));

  always_comb begin
    ph_d      = ph_q;
    idx_d     = idx_q;
    len_d     = len_q;
    mode_d    = mode_q;
    found_d   = found_q;
    st_d      = st_q;
    err_d     = err_q;
    done_d    = 1'b0;
    rep_d     = 1'b0;
    rep_off_d = rep_off_q;
    rep_len_d = rep_len_q;
    ov_d      = fwd;
    ob_d      = fwd ? win_out : ob_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (start) begin
          len_d   = total_len;
          mode_d  = mode_t'(mode);
          idx_d   = '0;
          found_d = 1'b0;
          st_d    = '0;
          err_d   = 1'b0;
          if (total_len == '0) begin
            done_d = 1'b1;
            err_d  = 1'b1;
          end else begin
            ph_d = PH_FEED;
          end
        end
      end
      PH_FEED: begin
        if (take) begin
          idx_d = idx_q + IDX_W'(1);
          if (hit) begin
            found_d   = 1'b1;
            st_d      = hit_start;
            rep_d     = 1'b1;
            rep_off_d = LEN_W'(hit_start);
            rep_len_d = len_q - LEN_W'(hit_start);
          end
          if (last_in) begin
            if (!found_nx) begin
              err_d  = 1'b1;
              done_d = 1'b1;
              ph_d   = PH_IDLE;
            end else begin
              ph_d = PH_DRAIN;
            end
          end
        end
      end
      PH_DRAIN: begin
        idx_d = idx_q + IDX_W'(1);
        if (last_drain) begin
          done_d = 1'b1;
          ph_d   = PH_IDLE;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ph_q      <= PH_IDLE;
      idx_q     <= '0;
      len_q     <= '0;
      mode_q    <= MODE_PACKED;
      found_q   <= 1'b0;
      st_q      <= '0;
      err_q     <= 1'b0;
      done_q    <= 1'b0;
      rep_q     <= 1'b0;
      rep_off_q <= '0;
      rep_len_q <= '0;
      ov_q      <= 1'b0;
      ob_q      <= '0;
    end else begin
      ph_q      <= ph_d;
      idx_q     <= idx_d;
      len_q     <= len_d;
      mode_q    <= mode_d;
      found_q   <= found_d;
      st_q      <= st_d;
      err_q     <= err_d;
      done_q    <= done_d;
      rep_q     <= rep_d;
      rep_off_q <= rep_off_d;
      rep_len_q <= rep_len_d;
      ov_q      <= ov_d;
      ob_q      <= ob_d;
    end
  end

  assign busy      = (ph_q != PH_IDLE);
  assign out_valid = ov_q;
  assign out_byte  = ob_q;
  assign rep_valid = rep_q;
  assign start_off = rep_off_q;
  assign pay_len   = rep_len_q;
  assign done      = done_q;
  assign err       = err_q;

endmodule

// File: rtl/cfl_locator_chk.sv
module cfl_locator_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LEN_W-1:0] total_len,
  input logic             busy,
  input logic             out_valid,
  input logic             rep_valid,
  input logic             done,
  input logic             err
);

  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 seen_q <= 1'b0;
    else if (start && !busy)    seen_q <= 1'b0;
    else if (rep_valid)         seen_q <= 1'b1;
  end

  a_r1_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (total_len != '0)) |=> busy);

  a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);

  a_r5_single_report: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid |=> !rep_valid);

  a_r5_report_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid |-> busy);

  a_r6_fwd_after_report: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (seen_q || rep_valid));

  a_r6_fwd_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (busy || done));

  a_r7_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!out_valid && !rep_valid));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind cfl_locator cfl_locator_chk #(.LEN_W(LEN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .start     (start),
  .total_len (total_len),
  .busy      (busy),
  .out_valid (out_valid),
  .rep_valid (rep_valid),
  .done      (done),
  .err       (err)
);

// File: tb/tb_cfl_locator.sv
module tb_cfl_locator;

  localparam int LW = 16;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic          mode;
  logic [LW-1:0] total_len;
  logic          in_valid;
  logic [7:0]    in_byte;
  logic          busy, out_valid, rep_valid, done, err;
  logic [7:0]    out_byte;
  logic [LW-1:0] start_off, pay_len;

  cfl_locator #(.LEN_W(LW)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode      (mode),
    .total_len (total_len),
    .in_valid  (in_valid),
    .in_byte   (in_byte),
    .busy      (busy),
    .out_valid (out_valid),
    .out_byte  (out_byte),
    .rep_valid (rep_valid),
    .start_off (start_off),
    .pay_len   (pay_len),
    .done      (done),
    .err       (err)
  );

  int         n_chk = 0;
  int         n_fail = 0;
  int         cyc = 0;
  logic [7:0] img[$];
  logic [7:0] exp_q[$];
  bit         exp_found;
  int         exp_start;
  int         cur_len;
  string      cur_tag;
  bit         mon_on = 0;
  bit         done_seen;
  int         rep_cnt;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(bit ok, string tag, string what, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL R8 watchdog expired: got %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // per-clock comparison against the behavioural model's queue
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R6", "unexpected payload byte", out_byte, -1);
        else begin
          chk(out_byte == exp_q[0], "R6", "payload byte", out_byte, exp_q[0]);
          void'(exp_q.pop_front());
        end
      end
      if (rep_valid) begin
        rep_cnt++;
        chk(exp_found, cur_tag, "report raised", 1, exp_found);
        chk(start_off == LW'(exp_start), cur_tag, "start offset", start_off, exp_start);
        chk(pay_len == LW'(cur_len - exp_start), "R5", "payload length", pay_len, cur_len - exp_start);
      end
      if (done) done_seen = 1;
    end
  end

  task automatic build_hdr(int l0, int l1, int l2, int l3, logic [7:0] fill);
    int ls[4];
    ls = '{l0, l1, l2, l3};
    img.delete();
    for (int i = 0; i < 15; i++) img.push_back(8'(i));
    for (int f = 0; f < 4; f++) begin
      img.push_back(8'(ls[f]));
      repeat (ls[f] + 2) img.push_back(fill);
    end
  endtask

  task automatic add(logic [7:0] b);
    img.push_back(b);
  endtask

  task automatic model(bit md);
    int ptr;
    bit ok;
    ptr = 15;
    ok = 1;
    exp_found = 0;
    exp_start = 0;
    exp_q.delete();
    for (int f = 0; f < 4; f++) begin
      if (ptr >= cur_len) begin ok = 0; break; end
      ptr = ptr + int'(img[ptr]) + 3;
    end
    if (ok) begin
      if (!md) begin
        for (int i = ptr; i + 1 < cur_len; i++)
          if (img[i] == 8'hFF && img[i+1][7:4] == 4'h3) begin
            exp_found = 1; exp_start = i + 2; break;
          end
      end else begin
        for (int i = ptr; i + 3 < cur_len; i++)
          if (img[i] == 8'hFF && img[i+1] == 8'hFF && img[i+2] == 8'hFF && img[i+3] == 8'hFF) begin
            exp_found = 1; exp_start = i; break;
          end
      end
    end
    if (exp_found)
      for (int i = exp_start; i < cur_len; i++) exp_q.push_back(img[i]);
  endtask

  task automatic run_case(string tag, bit md, bit gaps, bit disturb);
    cur_tag   = tag;
    cur_len   = img.size();
    model(md);
    rep_cnt   = 0;
    done_seen = 0;
    mon_on    = 1;
    @(negedge clk);
    start = 1; mode = md; total_len = LW'(cur_len);
    @(negedge clk);
    start = 0;
    for (int i = 0; i < cur_len; i++) begin
      if (gaps && (i % 3 == 1)) begin
        in_valid = 0; in_byte = 8'hFF;
        @(negedge clk);
      end
      if (disturb && i == 20) begin
        mode = ~md; start = 1; total_len = LW'(5);   // R1: ignored mid-run
      end
      in_valid = 1; in_byte = img[i];
      @(negedge clk);
      start = 0;
    end
    // R9: in gap runs keep feeding marker bytes after the end
    in_valid = gaps; in_byte = 8'hFF;
    for (int w = 0; w < 40 && !done_seen; w++) @(negedge clk);
    in_valid = 0;
    chk(done_seen, "R8", "done pulse seen", done_seen, 1);
    chk(err == !exp_found, "R7", "err flag", err, !exp_found);
    chk(exp_q.size() == 0, "R6", "payload bytes left over", exp_q.size(), 0);
    chk(rep_cnt == (exp_found ? 1 : 0), "R5", "report count", rep_cnt, exp_found ? 1 : 0);
    chk(!busy, "R1", "busy after done", busy, 0);
    repeat (3) @(negedge clk);
    chk(!out_valid && !rep_valid && !busy, "R9", "quiet while idle with in_valid", out_valid, 0);
    mon_on = 0;
  endtask

  initial begin
    rst_n = 0; start = 0; mode = 0; total_len = '0; in_valid = 0; in_byte = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!busy && !out_valid && !rep_valid, "R1", "reset outputs idle", busy, 0);
    chk(!done && !err, "R8", "reset done/err low", done, 0);

    // packed marker with a decoy pair inside the first field
    build_hdr(2, 0, 5, 1, 8'h30);
    img[16] = 8'hFF;
    add(8'h12); add(8'hFF); add(8'h43); add(8'hFF); add(8'h35);
    for (int i = 0; i < 10; i++) add(8'(8'hA0 + i));
    run_case("R3", 0, 0, 0);

    // packed: FF FF 3x
    build_hdr(1, 3, 0, 2, 8'h55);
    add(8'hFF); add(8'hFF); add(8'h37);
    for (int i = 0; i < 6; i++) add(8'(8'h10 * i));
    run_case("R3", 0, 1, 0);

    // packed: no marker
    build_hdr(2, 2, 2, 2, 8'h11);
    add(8'hFF); add(8'h20); add(8'hFF); add(8'h4F); add(8'h33);
    run_case("R7", 0, 0, 0);

    // packed: marker at the very end, empty payload
    build_hdr(0, 0, 0, 0, 8'h22);
    add(8'h01); add(8'hFF); add(8'h3F);
    run_case("R5", 0, 0, 0);

    // raw: plain four-FF marker
    build_hdr(3, 1, 4, 0, 8'h44);
    add(8'h11); add(8'h22);
    repeat (4) add(8'hFF);
    for (int i = 0; i < 8; i++) add(8'(8'hC0 + i));
    run_case("R4", 1, 0, 0);

    // raw: broken run, then a run of six; decoy runs in header, gaps
    build_hdr(1, 4, 2, 1, 8'hFF);
    repeat (3) add(8'hFF);
    add(8'h00);
    repeat (6) add(8'hFF);
    add(8'h55); add(8'h66);
    run_case("R4", 1, 1, 0);

    // raw: only three FF
    build_hdr(0, 1, 0, 1, 8'h77);
    repeat (3) add(8'hFF);
    add(8'h01);
    run_case("R7", 1, 0, 0);

    // header points past the stream
    build_hdr(1, 1, 1, 0, 8'h33);
    img[img.size() - 3] = 8'd200;
    add(8'hFF); add(8'h31); add(8'h99);
    run_case("R2", 0, 0, 0);

    // mode toggled and extra start mid-run: packed rule must stay
    build_hdr(0, 0, 0, 0, 8'h66);
    repeat (4) add(8'hFF);
    add(8'h36);
    for (int i = 0; i < 5; i++) add(8'(8'h70 + i));
    run_case("R1", 0, 1, 1);

    // zero length
    img.delete();
    run_case("R7", 0, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule